// File: doc/BRIEF.md
# Fractional clock rate controller

This block turns a parent clock into a clock-enable pulse train whose average rate is a programmable fraction, in steps of one thirty-second, of the parent rate. Software sets a five-bit reduction value in a control register. The multiplier is thirty-two minus that value, so a value of zero gives full rate and the largest value gives one pulse in every thirty-two cycles.

A new ratio does not take effect when it is written. Software commits it by setting a kick bit in a second register. The hardware copies the ratio at the next 32-cycle frame boundary and clears the kick bit on that same edge. Software polls the kick bit until it reads zero, which takes at most one frame. Within each frame, a phase accumulator spreads the pulses as evenly as the ratio allows.

Top module: `frac_rate_ctrl`

## Requirements
- R1: After reset, the reduction field reads 0, the kick bit reads 0, and `clk_en_o` is high on every cycle.
- R2: The reduction field sits at bits 12:8 of the control register at offset 0x20. All other bits of that register read 0 and ignore writes. Writes to unmapped offsets change nothing.
- R3: The kick bit is bit 31 of the register at offset 0x04. Writing 1 there sets it, and it reads 1 until the update has finished, then reads 0. Writing 0 to it has no effect.
- R4: The multiplier is 32 minus the applied field value, giving a range of 1 to 32. In steady state, every 32 consecutive cycles contain exactly that many enable pulses.
- R5: Writing the field does not change the output rate until a kick is issued.
- R6: The new ratio is applied only at a 32-cycle frame boundary, and the kick bit clears on that same edge. Clear events therefore lie a multiple of 32 cycles apart, and each one comes no more than 32 cycles after the kick write.
- R7: A field write made while a kick is pending is stored and reads back, but the pending update applies the value captured when the kick was written.
- R8: The pulses are spread evenly. Gaps between consecutive enable pulses differ by at most one cycle, and the shortest gap is at least floor(32/multiplier).
- R9: Writing the kick bit again while an update is pending neither restarts nor delays that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 8 | Register byte offset for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| clk_en_o | output | 1 | Registered clock enable for the divided domain |

## Verification
Some properties are checked on every cycle by the assertions:
- the kick bit falls only on a frame-boundary edge;
- the applied ratio changes only when a pending commit meets a boundary;
- the captured ratio stays frozen while a kick is pending;
- the accumulator is empty at every frame start;
- each frame carries exactly the multiplier's count of pulses.

Other behaviours only the bench scenarios can show. These are:
- the register field positions and the read-back of unmapped bits;
- a staged field having no effect before a kick;
- even spacing of the pulses, judged by measured gaps;
- repeated kicks and mid-update field writes leaving the committed value intact.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_KICK
  } reg_sel_e;

  localparam int unsigned DEF_ADDR_W    = 8;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_FRAC_W    = 5;
  localparam int unsigned DEF_FIELD_LSB = 8;
  localparam int unsigned DEF_KICK_BIT  = 31;
  localparam int unsigned DEF_CTRL_OFS  = 'h20;
  localparam int unsigned DEF_KICK_OFS  = 'h04;

endpackage

// File: rtl/frac_rate_frame.sv
module frac_rate_frame #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic frame_first_o,
  output logic frame_last_o
);

  logic [FRAC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign frame_first_o = (cnt_q == '0);
  assign frame_last_o  = &cnt_q;

endmodule

// File: rtl/frac_rate_regs.sv
module frac_rate_regs
  import frac_rate_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned FRAC_W    = DEF_FRAC_W,
  parameter int unsigned FIELD_LSB = DEF_FIELD_LSB,
  parameter int unsigned KICK_BIT  = DEF_KICK_BIT,
  parameter int unsigned CTRL_OFS  = DEF_CTRL_OFS,
  parameter int unsigned KICK_OFS  = DEF_KICK_OFS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              commit_i,
  output logic [FRAC_W-1:0] active_red_o
);

  reg_sel_e          sel;
  logic [FRAC_W-1:0] field_q;
  logic [FRAC_W-1:0] staged_q;
  logic [FRAC_W-1:0] active_q;
  logic              pending_q;
  logic              kick_req;
  logic              unused_wdata;

  always_comb begin
    if (addr_i == ADDR_W'(CTRL_OFS))      sel = SEL_CTRL;
    else if (addr_i == ADDR_W'(KICK_OFS)) sel = SEL_KICK;
    else                                  sel = SEL_NONE;
  end

  assign kick_req     = wr_en_i && (sel == SEL_KICK) && wdata_i[KICK_BIT];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) field_q <= '0;
    else if (wr_en_i && sel == SEL_CTRL) field_q <= wdata_i[FIELD_LSB +: FRAC_W];
  end

  // Commit on the boundary; a kick while pending is dropped.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      staged_q  <= '0;
      active_q  <= '0;
    end else if (pending_q && commit_i) begin
      pending_q <= 1'b0;
      active_q  <= staged_q;
    end else if (!pending_q && kick_req) begin
      pending_q <= 1'b1;
      staged_q  <= field_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel == SEL_CTRL)      rdata_o[FIELD_LSB +: FRAC_W] = field_q;
    else if (sel == SEL_KICK) rdata_o[KICK_BIT] = pending_q;
  end

  assign active_red_o = active_q;

  assert_kick_clears_on_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pending_q) |-> $past(commit_i));

  assert_kick_done_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && commit_i) |=> !pending_q);

  assert_ratio_holds_until_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> $past(pending_q && commit_i));

  assert_staged_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && $past(pending_q)) |-> $stable(staged_q));

endmodule

// File: rtl/frac_rate_accum.sv
module frac_rate_accum #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FRAC_W:0] mult_i,
  input  logic            frame_first_i,
  input  logic            frame_last_i,
  output logic            en_o
);

  localparam logic [FRAC_W:0] FRAME = (FRAC_W+1)'(1) << FRAC_W;

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic              hit;
  logic              en_q;
  logic [FRAC_W:0]   pulse_cnt_q;

  assign sum = {1'b0, acc_q} + mult_i;
  assign hit = (sum >= FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      acc_q <= hit ? FRAC_W'(sum - FRAME) : sum[FRAC_W-1:0];
      en_q  <= hit;
    end
  end

  assign en_o = en_q;

  // Per-frame pulse tally, used only by the checks below.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pulse_cnt_q <= '0;
    else if (frame_last_i) pulse_cnt_q <= '0;
    else                   pulse_cnt_q <= pulse_cnt_q + {{FRAC_W{1'b0}}, hit};
  end

  assert_mult_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mult_i != '0) && (mult_i <= FRAME));

  assert_frame_pulse_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last_i |-> ((pulse_cnt_q + {{FRAC_W{1'b0}}, hit}) == mult_i));

  assert_acc_empty_at_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_first_i |-> (acc_q == '0));

endmodule

// File: rtl/frac_rate_ctrl.sv
module frac_rate_ctrl
  import frac_rate_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned FRAC_W    = DEF_FRAC_W,
  parameter int unsigned FIELD_LSB = DEF_FIELD_LSB,
  parameter int unsigned KICK_BIT  = DEF_KICK_BIT,
  parameter int unsigned CTRL_OFS  = DEF_CTRL_OFS,
  parameter int unsigned KICK_OFS  = DEF_KICK_OFS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clk_en_o
);

  localparam logic [FRAC_W:0] FRAME = (FRAC_W+1)'(1) << FRAC_W;

  logic              frame_first;
  logic              frame_last;
  logic [FRAC_W-1:0] active_red;
  logic [FRAC_W:0]   mult;

  frac_rate_frame #(.FRAC_W(FRAC_W)) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_first_o (frame_first),
    .frame_last_o  (frame_last)
  );

  frac_rate_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .FRAC_W    (FRAC_W),
    .FIELD_LSB (FIELD_LSB),
    .KICK_BIT  (KICK_BIT),
    .CTRL_OFS  (CTRL_OFS),
    .KICK_OFS  (KICK_OFS)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .commit_i     (frame_last),
    .active_red_o (active_red)
  );

  assign mult = FRAME - {1'b0, active_red};

  frac_rate_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mult_i        (mult),
    .frame_first_i (frame_first),
    .frame_last_i  (frame_last),
    .en_o          (clk_en_o)
  );

endmodule

// File: tb/frac_rate_ctrl_test.sv
`timescale 1ns/1ps
module frac_rate_ctrl_test;

  localparam logic [7:0] CTRL_A = 8'h20;
  localparam logic [7:0] KICK_A = 8'h04;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        clk_en_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int c0 = -1;
  int cur_mult = 32;
  bit done = 0;

  frac_rate_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .clk_en_o(clk_en_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic int mult_of(input int field);
    return 32 - (field & 31);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    cyc++;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // Count pulses over n cycles and the spread of gaps between them.
  task automatic window(input int n, output int cnt, output int gmin, output int gmax);
    int last = -1;
    cnt = 0; gmin = 1000; gmax = 0;
    for (int i = 0; i < n; i++) begin
      if (clk_en_o) begin
        cnt++;
        if (last >= 0) begin
          if (i - last < gmin) gmin = i - last;
          if (i - last > gmax) gmax = i - last;
        end
        last = i;
      end
      tick();
    end
  endtask

  task automatic check_rate(input int m, input string req);
    int cnt, gmin, gmax;
    window(64, cnt, gmin, gmax);
    check(cnt == 2 * m, req, cnt, 2 * m);
    check((gmax - gmin) <= 1 && gmin >= 32 / m, "R8 gap spread", gmax - gmin, 0);
  endtask

  task automatic poll_clear(input int k0, input string req);
    logic [31:0] d;
    int n = 0;
    addr_i = KICK_A;
    #1 d = rdata_o;
    while (d[31] && n < 40) begin
      tick(); n++;
      #1 d = rdata_o;
    end
    check(d[31] == 1'b0 && (cyc - k0) <= 32, {req, " clear latency"}, cyc - k0, 32);
    if (c0 < 0) c0 = cyc;
    else check(((cyc - c0) % 32) == 0, "R6 clear on frame boundary", (cyc - c0) % 32, 0);
  endtask

  task automatic kick(input string req);
    logic [31:0] d;
    int k0;
    wr(KICK_A, 32'h8000_0000);
    k0 = cyc;
    rd(KICK_A, d);
    check(d[31] == 1'b1, "R3 kick reads set while pending", int'(d[31]), 1);
    poll_clear(k0, req);
  endtask

  task automatic wait_phase(input int p);
    while (((cyc - c0) % 32) != p) tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int f, m;
    void'($urandom(32'd4242));
    repeat (4) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    rd(CTRL_A, d); check(d == 32'h0, "R1 field after reset", d, 0);
    rd(KICK_A, d); check(d == 32'h0, "R1 kick after reset", d, 0);
    check_rate(32, "R1 full rate after reset");

    // R2 field position, masking, unmapped offsets
    wr(CTRL_A, 32'hFFFF_FFFF);
    rd(CTRL_A, d); check(d == 32'h0000_1F00, "R2 field readback", d, 32'h1F00);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(CTRL_A, 32'h0000_1F00 | 32'hFFFF_E0FF);
    rd(CTRL_A, d); check(d == 32'h0000_1F00, "R2 unmapped write ignored", d, 32'h1F00);
    // R5 no change before kick
    check_rate(32, "R5 rate unchanged before kick");
    // R3 writing 0 to kick is a no-op
    wr(KICK_A, 32'h7FFF_FFFF);
    rd(KICK_A, d); check(d == 32'h0, "R3 kick write of 0", d, 0);
    check_rate(32, "R3 rate after zero kick");
    kick("R6");
    cur_mult = 1;
    repeat (34) tick();
    check_rate(1, "R4 minimum rate");

    // R7 and R9: field write and repeat kick while pending
    wait_phase(2);
    wr(CTRL_A, 32'd10 << 8);
    begin
      int k0;
      wr(KICK_A, 32'h8000_0000);
      k0 = cyc;
      wr(CTRL_A, 32'd20 << 8);
      rd(CTRL_A, d); check(d == (32'd20 << 8), "R7 field write while pending stored", d, 32'd20 << 8);
      wr(KICK_A, 32'h8000_0000);
      poll_clear(k0, "R9 repeat kick");
    end
    repeat (34) tick();
    check_rate(22, "R7 captured value applied");
    kick("R6");
    repeat (34) tick();
    check_rate(12, "R7 later kick applies stored field");
    cur_mult = 12;

    // Constrained random ratios
    for (int i = 0; i < 16; i++) begin
      f = $urandom % 32;
      if (i == 0) f = 0;
      m = mult_of(f);
      wr(CTRL_A, (f << 8) | ($urandom & 32'hFFFF_E0FF));
      check_rate(cur_mult, "R5 staged field inert");
      kick("R6");
      repeat (34) tick();
      check_rate(m, "R4 rate matches 32 minus field");
      cur_mult = m;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule